// File: doc/BRIEF.md
# Microwire EEPROM Configuration Autoloader

After reset is released, this block optionally fetches seven 16-bit words from an external serial EEPROM over a Microwire bus (chip select, serial clock, data to the device, data from the device). It copies the relevant words into host-visible configuration outputs: a 48-bit station address and a bus-width select bit. Before issuing the first command it does not know whether a 6-bit or an 8-bit address device is attached. It works this out while reading word 0.

A single enable input decides whether the fetch happens at all. Once the fetch is over, or skipped, the block hands the bus pins to a small control register at a fixed host offset. A software driver then toggles chip select, clock and data directly. It reads the device's data-out line through the same register, which lets it perform any read or write command.

Top module: `ee_cfg_loader`

## Requirements
- R1: While `rst_n` is low, `ee_cs` and `ee_sk` are 0, `station_addr` equals the `DEF_STATION` parameter and `bus16` equals the `DEF_BUS16` parameter.
- R2: With `load_en` low at reset release, chip select never rises, the configuration outputs keep their defaults, and `busy` clears within two clocks.
- R3: With `load_en` high, the block issues exactly seven read commands. Each command is a start bit 1, then opcode bits 1,0, then the address MSB first. The addresses are 0,1,2,3,4,5,6 in that order, after which `busy` falls.
- R4: While reading word 0, the block sends address zeros and samples data-out after each serial clock. If data-out is 0 after the sixth address bit, it uses 6-bit addresses; otherwise it uses 8-bit addresses. Words are read correctly from both device sizes.
- R5: Word 1 loads `station_addr[15:0]`, word 2 loads `station_addr[31:16]` and word 3 loads `station_addr[47:32]`. In each word the high byte is the later address byte. Words 0, 4 and 5 change no output.
- R6: Bit 0 of word 6 loads `bus16` (1 = 16-bit bus, 0 = 8-bit bus). Bits 15..1 of word 6 are ignored.
- R7: The serial clock runs at one eighth of `clk` and is high for 4 cycles of each 8. It stays low while chip select is low during the load. Chip select stays low for at least 8 clocks between commands. Data-out is sampled at the end of each high phase, and a 0 dummy bit precedes the 16 data bits.
- R8: `busy` is 1 throughout the load and never returns to 1 after it clears. Control register writes made while `busy` is 1 are ignored.
- R9: The control register is at host offset 0x22 (`CTL_OFFSET`). Its fields are bit 0 chip select, bit 1 serial clock, bit 2 data to the device, bit 3 data-out (read only) and bit 4 busy (read only). Other offsets read 0. When `busy` is 0, the pins follow bits 0..2.
- R10: Bit 3 of the control register reads the live data-out line, so that a driver can bit-bang complete read and write commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Enables the automatic load after reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM (pulled high when idle) |
| sw_addr | input | 8 | Host register offset |
| sw_wr | input | 1 | Host write strobe |
| sw_wdata | input | 16 | Host write data |
| sw_rdata | output | 16 | Host read data for the addressed offset |
| station_addr | output | 48 | Loaded station address |
| bus16 | output | 1 | Bus width select, 1 = 16-bit |
| busy | output | 1 | Load in progress |

## Verification
The hardest situation to reach is the size decision. It depends on the exact bit at which the device starts to drive its dummy zero, and that bit only appears during the very first command. The bench therefore uses a behavioural EEPROM whose address width can be changed, and reruns the whole reset-and-load sequence once with 6-bit addressing and once with 8-bit addressing. The stored words differ between the two runs, so a wrong decision turns into visibly misaligned data. A second situation that is hard to reach is a software write landing while the load is in progress: the bench issues such a write mid-load and then inspects the pins and the register once the load is over.

// File: rtl/ee_cfg_loader.sv
module ee_cfg_loader #(
  parameter logic [7:0]  CTL_OFFSET  = 8'h22,
  parameter logic [47:0] DEF_STATION = 48'h0,
  parameter logic        DEF_BUS16   = 1'b1,
  parameter int          DIV_LOG2    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  input  logic [7:0]  sw_addr,
  input  logic        sw_wr,
  input  logic [15:0] sw_wdata,
  output logic [15:0] sw_rdata,
  output logic [47:0] station_addr,
  output logic        bus16,
  output logic        busy
);
  typedef enum logic [1:0] {S_START, S_GAP, S_SHIFT, S_DONE} st_t;

  st_t                 st;
  logic [DIV_LOG2-1:0] div;
  logic [4:0]          bitn;
  logic [2:0]          wrd;
  logic                ab6;
  logic [14:0]         sr;
  logic [2:0]          ctl;
  logic [4:0]          last_addr, last_bit;
  logic [7:0]          addr8;
  logic [2:0]          aidx;
  logic                slot_end, shifting, auto_di, ctl_hit;
  logic                unused_wdata;

  assign busy      = (st != S_DONE);
  assign shifting  = (st == S_SHIFT);
  assign slot_end  = &div;
  assign last_addr = ab6 ? 5'd8 : 5'd10;
  assign last_bit  = last_addr + 5'd16;
  assign addr8     = {5'd0, wrd};
  assign aidx      = 3'(last_addr - bitn);
  assign ctl_hit   = (sw_addr == CTL_OFFSET);
  assign unused_wdata = ^sw_wdata[15:3];

  always_comb begin
    if (bitn <= 5'd1)                        auto_di = 1'b1;
    else if (bitn >= 5'd3 && bitn <= last_addr) auto_di = addr8[aidx];
    else                                      auto_di = 1'b0;
  end

  assign ee_cs    = busy ? shifting : ctl[0];
  assign ee_sk    = busy ? (shifting & div[DIV_LOG2-1]) : ctl[1];
  assign ee_di    = busy ? (shifting & auto_di) : ctl[2];
  assign sw_rdata = ctl_hit ? {11'd0, busy, ee_do, ctl} : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_START;
      div          <= '0;
      bitn         <= '0;
      wrd          <= '0;
      ab6          <= 1'b0;
      sr           <= '0;
      ctl          <= '0;
      station_addr <= DEF_STATION;
      bus16        <= DEF_BUS16;
    end else begin
      case (st)
        S_START: begin
          div <= '0;
          st  <= load_en ? S_GAP : S_DONE;
        end
        S_GAP: begin
          div <= div + 1'b1;
          if (slot_end) begin
            bitn <= '0;
            st   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          div <= div + 1'b1;
          if (slot_end) begin
            bitn <= bitn + 1'b1;
            if (bitn > last_addr) sr <= {sr[13:0], ee_do};
            if (wrd == 3'd0 && bitn == 5'd8 && !ee_do) ab6 <= 1'b1;
            if (bitn == last_bit) begin
              case (wrd)
                3'd1:    station_addr[15:0]  <= {sr, ee_do};
                3'd2:    station_addr[31:16] <= {sr, ee_do};
                3'd3:    station_addr[47:32] <= {sr, ee_do};
                3'd6:    bus16               <= ee_do;
                default: ;
              endcase
              wrd <= wrd + 1'b1;
              st  <= (wrd == 3'd6) ? S_DONE : S_GAP;
            end
          end
        end
        default: begin
          if (sw_wr && ctl_hit) ctl <= sw_wdata[2:0];
        end
      endcase
    end
  end
endmodule

module ee_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic [2:0] ctl
);
  AST_CTL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(ctl)); // R8
  AST_BUSY_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> !busy); // R8
  AST_SK_LOW_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (busy && !ee_cs) |-> !ee_sk); // R7
  AST_SK_HIGH_SPAN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $fell(ee_sk)) |-> $past(ee_sk, 4)); // R7
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n) (busy && $rose(ee_cs)) |-> !$past(ee_cs, 8)); // R7
endmodule

bind ee_cfg_loader ee_cfg_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ee_cs(ee_cs), .ee_sk(ee_sk), .ctl(ctl)
);

// File: tb/ee_cfg_loader_tb_top.sv
module ee_cfg_loader_tb_top;
  localparam logic [47:0] DEF_ST = 48'hA5A5_0011_2233;

  logic clk = 1'b0, rst_n = 1'b0, load_en = 1'b0, sw_wr = 1'b0;
  logic [7:0]  sw_addr = 8'h22;
  logic [15:0] sw_wdata = 16'd0;
  logic        ee_do_m = 1'b1;
  wire         ee_cs, ee_sk, ee_di, bus16, busy;
  wire  [15:0] sw_rdata;
  wire  [47:0] station_addr;

  always #5 clk = ~clk;

  ee_cfg_loader #(.DEF_STATION(DEF_ST), .DEF_BUS16(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do_m),
    .sw_addr(sw_addr), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .station_addr(station_addr), .bus16(bus16), .busy(busy)
  );

  int checks = 0, fails = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // behavioural EEPROM
  logic [15:0] mem [256];
  int          ab = 6;
  bit          started = 0;
  int          cnt = 0;
  logic [1:0]  op;
  logic [7:0]  ad;
  logic [15:0] sh;
  int          addr_log[$];

  always @(negedge ee_cs) begin
    started = 0;
    cnt = 0;
    ee_do_m = 1'b1;
  end

  always @(posedge ee_sk) if (ee_cs) begin
    if (!started) begin
      if (ee_di) begin started = 1; cnt = 0; op = 2'b00; ad = 8'd0; end
    end else begin
      cnt++;
      if (cnt <= 2) op = {op[0], ee_di};
      else if (cnt <= 2 + ab) begin
        ad = {ad[6:0], ee_di};
        if (cnt == 2 + ab && op == 2'b10) begin
          addr_log.push_back(int'(ad));
          sh = mem[ad];
          ee_do_m = 1'b0;
        end
      end else if (op == 2'b10) begin
        ee_do_m = sh[15];
        sh = {sh[14:0], 1'b0};
      end else if (op == 2'b01) begin
        sh = {sh[14:0], ee_di};
        if (cnt == 2 + ab + 16) mem[ad] = sh;
      end
    end
  end

  // bus timing observers
  int cyc = 0, n_cmd = 0, min_gap = 1000, last_fall = -1, last_sk = -1, sk_bad = 0;
  always @(posedge clk) cyc++;
  always @(negedge ee_cs) last_fall = cyc;
  always @(posedge ee_cs) if (busy) begin
    n_cmd++;
    if (last_fall >= 0 && cyc - last_fall < min_gap) min_gap = cyc - last_fall;
    last_sk = -1;
  end
  always @(posedge ee_sk) if (busy) begin
    if (last_sk >= 0 && cyc - last_sk != 8) sk_bad++;
    last_sk = cyc;
  end

  // scoreboard
  typedef struct { string req; logic [48:0] val; } exp_t;
  exp_t q[$];

  initial forever begin
    @(negedge busy);
    #2;
    if (q.size() == 0) begin
      checks++; fails++;
      $display("FAIL R3 unexpected end of load actual=1 expected=0");
    end else begin
      exp_t e;
      e = q.pop_front();
      check(e.req, 64'({bus16, station_addr}), 64'(e.val));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  task automatic sw_write(logic [15:0] v);
    @(negedge clk);
    sw_addr = 8'h22; sw_wdata = v; sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic bb(bit cs, bit sk, bit di);
    sw_write({13'd0, di, sk, cs});
  endtask

  task automatic send_bit(bit b);
    bb(1, 0, b);
    bb(1, 1, b);
  endtask

  task automatic sw_read(logic [7:0] a, int abits, output logic [15:0] v);
    bb(1, 0, 0);
    send_bit(1); send_bit(1); send_bit(0);
    for (int i = abits - 1; i >= 0; i--) send_bit(a[i]);
    check("R10 dummy zero before data", 64'(sw_rdata[3]), 64'(0));
    v = 16'd0;
    for (int i = 0; i < 16; i++) begin
      send_bit(0);
      v = {v[14:0], sw_rdata[3]};
    end
    bb(0, 0, 0);
  endtask

  task automatic sw_write_word(logic [7:0] a, int abits, logic [15:0] d);
    bb(1, 0, 0);
    send_bit(1); send_bit(0); send_bit(1);
    for (int i = abits - 1; i >= 0; i--) send_bit(a[i]);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    bb(0, 0, 0);
  endtask

  task automatic run_load(string req, bit en, int abits, logic [48:0] exp, bit poke);
    @(negedge clk);
    rst_n = 1'b0; load_en = en; ab = abits;
    repeat (3) @(negedge clk);
    n_cmd = 0; min_gap = 1000; last_fall = -1; sk_bad = 0;
    addr_log.delete();
    q.push_back('{req, exp});
    rst_n = 1'b1;
    if (poke) begin
      repeat (40) @(negedge clk);
      check("R8 busy during load", 64'(busy), 64'(1));
      sw_write(16'h0007);
    end
    wait (!busy);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_cmds(string tag);
    check({"R3 command count ", tag}, 64'(n_cmd), 64'(7));
    check({"R3 addresses logged ", tag}, 64'(addr_log.size()), 64'(7));
    if (addr_log.size() == 7)
      for (int i = 0; i < 7; i++) check({"R3 address order ", tag}, 64'(addr_log[i]), 64'(i));
    check({"R7 chip select gap ", tag}, 64'(min_gap >= 8), 64'(1));
    check({"R7 serial clock period ", tag}, 64'(sk_bad), 64'(0));
  endtask

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5A5A;

    repeat (3) @(negedge clk);
    check("R1 reset cs", 64'(ee_cs), 64'(0));
    check("R1 reset sk", 64'(ee_sk), 64'(0));
    check("R1 reset station", 64'(station_addr), 64'(DEF_ST));
    check("R1 reset bus16", 64'(bus16), 64'(1));

    run_load("R2 defaults kept", 1'b0, 6, {1'b1, DEF_ST}, 1'b0);
    check("R2 no commands", 64'(n_cmd), 64'(0));
    check("R2 busy clear", 64'(busy), 64'(0));
    check("R9 R10 control readback", 64'(sw_rdata), 64'(16'h0008));
    sw_addr = 8'h20; #1;
    check("R9 other offset reads zero", 64'(sw_rdata), 64'(0));
    sw_addr = 8'h22;

    mem[0] = 16'hDEAD; mem[1] = 16'h2211; mem[2] = 16'h4433; mem[3] = 16'h6655;
    mem[4] = 16'hFFFF; mem[5] = 16'hFFFF; mem[6] = 16'hFFFE;
    run_load("R4 R5 R6 small device load", 1'b1, 6, {1'b0, 48'h6655_4433_2211}, 1'b1);
    check_cmds("small");
    check("R8 write during load ignored", 64'(sw_rdata[2:0]), 64'(0));
    check("R8 pins idle after ignored write", 64'(ee_cs), 64'(0));

    mem[0] = 16'h0000; mem[1] = 16'hBBAA; mem[2] = 16'hDDCC; mem[3] = 16'hFFEE;
    mem[4] = 16'h0000; mem[5] = 16'h0000; mem[6] = 16'h8001;
    run_load("R4 R5 R6 large device load", 1'b1, 8, {1'b1, 48'hFFEE_DDCC_BBAA}, 1'b0);
    check_cmds("large");

    sw_write(16'h0001);
    check("R9 cs follows bit 0", 64'(ee_cs), 64'(1));
    check("R9 busy bit clear", 64'(sw_rdata[4]), 64'(0));
    bb(0, 0, 0);
    sw_read(8'h02, 8, v);
    check("R10 bit-bang read", 64'(v), 64'(16'hDDCC));
    sw_write_word(8'h09, 8, 16'h1234);
    check("R10 bit-bang write", 64'(mem[9]), 64'(16'h1234));
    sw_read(8'h09, 8, v);
    check("R10 bit-bang read back", 64'(v), 64'(16'h1234));

    repeat (5) @(negedge clk);
    check("R3 scoreboard drained", 64'(q.size()), 64'(0));
    finish_run();
  end
endmodule